// File: doc/BRIEF.md
# Subcarrier Manchester Response Encoder

This block drives the load-modulation control of a contactless tag while it answers a reader. It runs on the recovered carrier clock, with one clock cycle per carrier period. From that clock it derives two subcarriers: a primary one with a period of `2*SC1_HALF` cycles and an alternate one with a period of `2*SC2_HALF` cycles. Each response is framed by a start marker, carries its bytes least significant bit first with Manchester coding, and closes with an end marker. Every half of a bit, and every part of a marker, is a counted burst of whole subcarrier pulses.

Three inputs are sampled when `start_i` is seen. They select one or two subcarriers, the low or high rate, and the fast mode. The low rate makes every segment four times as long. The fast mode halves the segments and exists only with one subcarrier. Bytes come from a response buffer through a valid/ready handshake, and one byte is held ahead so that bit timing has no gaps. The buffer marks the final byte with `byte_last_i`. After the end marker the block pulses `done_o`.

The same encoder handles both line formats. Each segment is either a primary burst (called MAIN) or the other half (called ALT). With one subcarrier, ALT is an unmodulated stretch that lasts as long as the MAIN burst. With two subcarriers, ALT is a burst on the alternate subcarrier.

Top module: `rsp_mod_encoder`

## Requirements
- R1: After reset, `mod_o`, `busy_o`, `byte_ready_o`, `done_o` and `illegal_o` are all 0.
- R2: One subcarrier, high rate, normal speed. A logic 1 is NP1 unmodulated pulse times followed by NP1 primary pulses. A logic 0 is the same two parts in the opposite order. A primary pulse is `mod_o` high for SC1_HALF cycles and then low for SC1_HALF cycles.
- R3: With one subcarrier, the low rate makes every pulse count four times larger. The fast mode halves every pulse count.
- R4: Two subcarriers. A logic 0 is NP1 primary pulses followed by NP2 alternate pulses. A logic 1 is the alternate pulses first and then the primary pulses. An alternate pulse is high for SC2_HALF cycles and then low for SC2_HALF cycles. The low rate makes both counts four times larger.
- R5: The start marker begins in the cycle after `start_i` is accepted. It consists of three ALT units, then three MAIN units, then a logic 1.
- R6: The end marker is a logic 0, then three MAIN units, then three ALT units. In the cycle after the last pulse, `done_o` is 1 for exactly one cycle and `busy_o` is 0.
- R7: Bytes are sent in the order they are accepted, each least significant bit first. The end marker follows directly after the byte that was flagged with `byte_last_i`. The block accepts no further bytes.
- R8: A start request with both the two-subcarrier and fast flags set is illegal. In the next cycle `illegal_o` is 1 for one cycle. The block stays idle, sends no modulation and accepts no byte.
- R9: `byte_ready_o` is 1 only while a frame is active, no byte is held, and the last byte has not yet been accepted. It is 0 while the block is idle.
- R10: With two subcarriers, every burst starts at the beginning of the high phase of a pulse. The frequency changes only at a pulse boundary, so the phase stays continuous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Carrier clock, one cycle per carrier period |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a response; the format inputs are sampled here |
| dual_sc_i | input | 1 | 1 selects the two-subcarrier format |
| low_rate_i | input | 1 | 1 selects the low rate (four-times-longer segments) |
| fast_i | input | 1 | 1 selects the fast mode (half-length segments) |
| byte_i | input | 8 | Response byte from the buffer |
| byte_valid_i | input | 1 | `byte_i` holds a byte |
| byte_last_i | input | 1 | The offered byte is the final one of the response |
| byte_ready_o | output | 1 | The encoder accepts the offered byte in this cycle |
| mod_o | output | 1 | Load-modulation control |
| busy_o | output | 1 | A frame is in progress |
| done_o | output | 1 | One-cycle pulse after the end marker |
| illegal_o | output | 1 | One-cycle pulse after an illegal format request |

## Verification
The bench builds the encoder with SC1_HALF=3, SC2_HALF=2, NP1=4 and NP2=5. With these values the two subcarriers have different periods and the two pulse counts differ. A low-rate frame is then short enough to run completely, so the bench can sweep all eight combinations of the format flags, including both illegal ones. For every frame the bench predicts `mod_o` cycle by cycle from the pulse arithmetic. It compares the start marker, each data bit and the end marker segment by segment, for data bytes that include all-zero, all-one and single-bit values.

// File: rtl/rsp_enc_pkg.sv
package rsp_enc_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SOF_QUIET,
        ST_SOF_BURST,
        ST_SOF_LEAD,
        ST_SOF_TAIL,
        ST_BIT_FIRST,
        ST_BIT_SECOND,
        ST_WAIT,
        ST_EOF_LEAD,
        ST_EOF_TAIL,
        ST_EOF_BURST,
        ST_EOF_QUIET
    } frame_state_e;

    typedef enum logic {
        SEG_ALT  = 1'b0,
        SEG_MAIN = 1'b1
    } seg_kind_e;

    typedef struct packed {
        logic dual;
        logic slow;
        logic fast;
    } fmt_t;

    localparam int unsigned SLOW_FACTOR = 4;
    localparam int unsigned MARK_FACTOR = 3;

    function automatic int unsigned main_pulses(input fmt_t f, input int unsigned base);
        int unsigned n;
        n = f.slow ? base * SLOW_FACTOR : base;
        return f.fast ? (n >> 1) : n;
    endfunction

    function automatic int unsigned alt_pulses(input fmt_t f, input int unsigned base1,
                                               input int unsigned base2);
        if (f.dual) return f.slow ? base2 * SLOW_FACTOR : base2;
        return main_pulses(f, base1);
    endfunction

    function automatic seg_kind_e kind_of(input frame_state_e s, input logic b);
        case (s)
            ST_SOF_BURST, ST_SOF_TAIL,
            ST_EOF_LEAD, ST_EOF_BURST: return SEG_MAIN;
            ST_BIT_FIRST:              return b ? SEG_ALT : SEG_MAIN;
            ST_BIT_SECOND:             return b ? SEG_MAIN : SEG_ALT;
            default:                   return SEG_ALT;
        endcase
    endfunction

    function automatic logic is_triple(input frame_state_e s);
        return (s == ST_SOF_QUIET) || (s == ST_SOF_BURST) ||
               (s == ST_EOF_BURST) || (s == ST_EOF_QUIET);
    endfunction

endpackage

// File: rtl/rsp_subcarrier_gen.sv
module rsp_subcarrier_gen #(
    parameter int unsigned SC1_HALF = 16,
    parameter int unsigned SC2_HALF = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic alt_freq,
    output logic wave,
    output logic pulse_end
);
    localparam int unsigned HMAX  = (SC1_HALF > SC2_HALF) ? SC1_HALF : SC2_HALF;
    localparam int unsigned CW    = $clog2(2 * HMAX);
    localparam int unsigned LAST1 = 2 * SC1_HALF - 1;
    localparam int unsigned LAST2 = 2 * SC2_HALF - 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] half;
    logic [CW-1:0] last;

    always_comb begin
        half      = alt_freq ? CW'(SC2_HALF) : CW'(SC1_HALF);
        last      = alt_freq ? CW'(LAST2) : CW'(LAST1);
        pulse_end = run && (cnt == last);
        wave      = run && (cnt < half);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || pulse_end) cnt <= '0;
        else                          cnt <= cnt + 1'b1;
    end

    a_r10_switch_on_boundary: assert property (@(posedge clk) disable iff (rst)
        (run && $past(run) && (alt_freq != $past(alt_freq))) |-> (cnt == '0));

endmodule

// File: rtl/rsp_byte_hold.sv
module rsp_byte_hold #(
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              open,
    input  logic              clear,
    input  logic              take,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              full,
    output logic [BYTE_W-1:0] data,
    output logic              last
);
    logic got_last;
    logic accept;

    assign in_ready = open && !full && !got_last;
    assign accept   = in_ready && in_valid;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            full     <= 1'b0;
            got_last <= 1'b0;
            data     <= '0;
            last     <= 1'b0;
        end else begin
            if (accept) begin
                full <= 1'b1;
                data <= in_data;
                last <= in_last;
                if (in_last) got_last <= 1'b1;
            end else if (take) begin
                full <= 1'b0;
            end
        end
    end

    a_r9_hold_stable: assert property (@(posedge clk) disable iff (rst)
        (full && !take && !clear) |=> (full && $stable(data)));

endmodule

// File: rtl/rsp_frame_seq.sv
module rsp_frame_seq
    import rsp_enc_pkg::*;
#(
    parameter int unsigned NP1    = 8,
    parameter int unsigned NP2    = 9,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  fmt_t              fmt_in,
    input  logic              pulse_end,
    input  logic              hold_full,
    input  logic [BYTE_W-1:0] hold_data,
    input  logic              hold_last,
    output logic              take,
    output logic              launch,
    output logic              run,
    output logic              alt_freq,
    output seg_kind_e         kind,
    output logic              busy,
    output logic              done,
    output logic              illegal
);
    localparam int unsigned NPMAX   = (NP1 > NP2) ? NP1 : NP2;
    localparam int unsigned SEG_MAX = MARK_FACTOR * SLOW_FACTOR * NPMAX;
    localparam int unsigned SEG_W   = $clog2(SEG_MAX + 1);
    localparam int unsigned IDX_W   = $clog2(BYTE_W);

    frame_state_e      state, st_n;
    fmt_t              fmt, fmt_n;
    logic [SEG_W-1:0]  seg_left, left_n;
    logic [BYTE_W-1:0] shreg, sh_n;
    logic [IDX_W-1:0]  bit_idx, idx_n;
    logic              cur_last, last_n;
    logic              done_n, ill_n, fetch, seg_end;

    function automatic logic [SEG_W-1:0] seg_len(input frame_state_e s, input logic b,
                                                 input fmt_t f);
        int unsigned u;
        if (kind_of(s, b) == SEG_MAIN) u = main_pulses(f, NP1);
        else                           u = alt_pulses(f, NP1, NP2);
        if (is_triple(s)) u = u * MARK_FACTOR;
        return SEG_W'(u);
    endfunction

    always_comb begin
        kind     = kind_of(state, shreg[0]);
        run      = (state != ST_IDLE) && (state != ST_WAIT);
        alt_freq = fmt.dual && (kind == SEG_ALT);
        busy     = (state != ST_IDLE);
        seg_end  = pulse_end && (seg_left == SEG_W'(1));
        launch   = (state == ST_IDLE) && start && !(fmt_in.dual && fmt_in.fast);
    end

    always_comb begin
        st_n   = state;
        fmt_n  = fmt;
        left_n = seg_left;
        sh_n   = shreg;
        idx_n  = bit_idx;
        last_n = cur_last;
        done_n = 1'b0;
        ill_n  = 1'b0;
        fetch  = 1'b0;
        take   = 1'b0;
        if (pulse_end && !seg_end) left_n = seg_left - 1'b1;
        case (state)
            ST_IDLE: begin
                if (start) begin
                    fmt_n = fmt_in;
                    if (fmt_in.dual && fmt_in.fast) begin
                        ill_n = 1'b1;
                    end else begin
                        st_n   = ST_SOF_QUIET;
                        left_n = seg_len(ST_SOF_QUIET, 1'b0, fmt_in);
                    end
                end
            end
            ST_SOF_QUIET: if (seg_end) begin
                st_n   = ST_SOF_BURST;
                left_n = seg_len(ST_SOF_BURST, 1'b0, fmt);
            end
            ST_SOF_BURST: if (seg_end) begin
                st_n   = ST_SOF_LEAD;
                left_n = seg_len(ST_SOF_LEAD, 1'b0, fmt);
            end
            ST_SOF_LEAD: if (seg_end) begin
                st_n   = ST_SOF_TAIL;
                left_n = seg_len(ST_SOF_TAIL, 1'b0, fmt);
            end
            ST_SOF_TAIL: if (seg_end) fetch = 1'b1;
            ST_BIT_FIRST: if (seg_end) begin
                st_n   = ST_BIT_SECOND;
                left_n = seg_len(ST_BIT_SECOND, shreg[0], fmt);
            end
            ST_BIT_SECOND: if (seg_end) begin
                if (bit_idx == IDX_W'(BYTE_W - 1)) begin
                    if (cur_last) begin
                        st_n   = ST_EOF_LEAD;
                        left_n = seg_len(ST_EOF_LEAD, 1'b0, fmt);
                    end else begin
                        fetch = 1'b1;
                    end
                end else begin
                    sh_n   = shreg >> 1;
                    idx_n  = bit_idx + 1'b1;
                    st_n   = ST_BIT_FIRST;
                    left_n = seg_len(ST_BIT_FIRST, shreg[1], fmt);
                end
            end
            ST_WAIT: fetch = 1'b1;
            ST_EOF_LEAD: if (seg_end) begin
                st_n   = ST_EOF_TAIL;
                left_n = seg_len(ST_EOF_TAIL, 1'b0, fmt);
            end
            ST_EOF_TAIL: if (seg_end) begin
                st_n   = ST_EOF_BURST;
                left_n = seg_len(ST_EOF_BURST, 1'b0, fmt);
            end
            ST_EOF_BURST: if (seg_end) begin
                st_n   = ST_EOF_QUIET;
                left_n = seg_len(ST_EOF_QUIET, 1'b0, fmt);
            end
            ST_EOF_QUIET: if (seg_end) begin
                st_n   = ST_IDLE;
                done_n = 1'b1;
            end
            default: st_n = ST_IDLE;
        endcase
        if (fetch) begin
            if (hold_full) begin
                take   = 1'b1;
                sh_n   = hold_data;
                last_n = hold_last;
                idx_n  = '0;
                st_n   = ST_BIT_FIRST;
                left_n = seg_len(ST_BIT_FIRST, hold_data[0], fmt);
            end else begin
                st_n = ST_WAIT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            fmt      <= '0;
            seg_left <= '0;
            shreg    <= '0;
            bit_idx  <= '0;
            cur_last <= 1'b0;
            done     <= 1'b0;
            illegal  <= 1'b0;
        end else begin
            state    <= st_n;
            fmt      <= fmt_n;
            seg_left <= left_n;
            shreg    <= sh_n;
            bit_idx  <= idx_n;
            cur_last <= last_n;
            done     <= done_n;
            illegal  <= ill_n;
        end
    end

    a_r6_done_after_frame: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    a_r8_illegal_stays_idle: assert property (@(posedge clk) disable iff (rst)
        illegal |-> (!busy && !run));

    a_r2_segment_countdown: assert property (@(posedge clk) disable iff (rst)
        (busy && pulse_end && (seg_left > SEG_W'(1))) |=> (seg_left == $past(seg_left) - 1'b1));

endmodule

// File: rtl/rsp_mod_encoder.sv
module rsp_mod_encoder
    import rsp_enc_pkg::*;
#(
    parameter int unsigned SC1_HALF = 16,
    parameter int unsigned SC2_HALF = 14,
    parameter int unsigned NP1      = 8,
    parameter int unsigned NP2      = 9
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       dual_sc_i,
    input  logic       low_rate_i,
    input  logic       fast_i,
    input  logic [7:0] byte_i,
    input  logic       byte_valid_i,
    input  logic       byte_last_i,
    output logic       byte_ready_o,
    output logic       mod_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       illegal_o
);
    localparam int unsigned BYTE_W = 8;

    fmt_t              fmt_in;
    logic              pulse_end, wave, run, alt_freq, take, launch;
    logic              hold_full, hold_last;
    logic [BYTE_W-1:0] hold_data;
    seg_kind_e         kind;

    assign fmt_in = '{dual: dual_sc_i, slow: low_rate_i, fast: fast_i};

    rsp_frame_seq #(.NP1(NP1), .NP2(NP2), .BYTE_W(BYTE_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start_i),
        .fmt_in    (fmt_in),
        .pulse_end (pulse_end),
        .hold_full (hold_full),
        .hold_data (hold_data),
        .hold_last (hold_last),
        .take      (take),
        .launch    (launch),
        .run       (run),
        .alt_freq  (alt_freq),
        .kind      (kind),
        .busy      (busy_o),
        .done      (done_o),
        .illegal   (illegal_o)
    );

    rsp_subcarrier_gen #(.SC1_HALF(SC1_HALF), .SC2_HALF(SC2_HALF)) u_sc (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .alt_freq  (alt_freq),
        .wave      (wave),
        .pulse_end (pulse_end)
    );

    rsp_byte_hold #(.BYTE_W(BYTE_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .open     (busy_o),
        .clear    (launch),
        .take     (take),
        .in_valid (byte_valid_i),
        .in_data  (byte_i),
        .in_last  (byte_last_i),
        .in_ready (byte_ready_o),
        .full     (hold_full),
        .data     (hold_data),
        .last     (hold_last)
    );

    assign mod_o = wave && ((kind == SEG_MAIN) || alt_freq);

    a_r9_no_ready_when_idle: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !byte_ready_o);

    a_r8_illegal_silent: assert property (@(posedge clk) disable iff (rst)
        illegal_o |-> (!mod_o && !byte_ready_o));

endmodule

// File: tb/rsp_mod_encoder_tb.sv
module rsp_mod_encoder_tb;
    localparam int PERIOD = 10;
    localparam int H1 = 3;
    localparam int H2 = 2;
    localparam int NP1 = 4;
    localparam int NP2 = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic dual_sc_i = 1'b0, low_rate_i = 1'b0, fast_i = 1'b0;
    logic [7:0] byte_i;
    logic byte_valid_i, byte_last_i;
    logic byte_ready_o, mod_o, busy_o, done_o, illegal_o;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    int nb_cur = 0;
    int idx = 0;
    logic [7:0] fbytes [4];

    always #(PERIOD/2) clk = ~clk;

    assign byte_valid_i = (idx < nb_cur);
    assign byte_i       = fbytes[(idx > 3) ? 3 : idx];
    assign byte_last_i  = (idx == nb_cur - 1);

    rsp_mod_encoder #(.SC1_HALF(H1), .SC2_HALF(H2), .NP1(NP1), .NP2(NP2)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .dual_sc_i(dual_sc_i),
        .low_rate_i(low_rate_i), .fast_i(fast_i), .byte_i(byte_i),
        .byte_valid_i(byte_valid_i), .byte_last_i(byte_last_i),
        .byte_ready_o(byte_ready_o), .mod_o(mod_o), .busy_o(busy_o),
        .done_o(done_o), .illegal_o(illegal_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Feeds the response buffer: a transfer happens on an edge where valid and ready are both high.
    initial begin
        forever begin
            bit xfer;
            @(negedge clk);
            xfer = byte_valid_i && byte_ready_o;
            @(posedge clk);
            #1;
            if (xfer) idx++;
        end
    end

    function automatic int p_main();
        int n;
        n = low_rate_i ? NP1 * 4 : NP1;
        return fast_i ? n / 2 : n;
    endfunction

    function automatic int p_alt();
        if (dual_sc_i) return low_rate_i ? NP2 * 4 : NP2;
        return p_main();
    endfunction

    // One segment: compares mod_o each cycle, starting in the current cycle.
    task automatic seg(input bit is_main, input int units, input string tag);
        int pulses, half, errs, act1, exp1;
        bit modded, m;
        pulses = (is_main ? p_main() : p_alt()) * units;
        half   = (!is_main && dual_sc_i) ? H2 : H1;
        modded = is_main || dual_sc_i;
        errs = 0; act1 = 0; exp1 = 0;
        for (int p = 0; p < pulses; p++) begin
            for (int c = 0; c < 2 * half; c++) begin
                m = modded && (c < half);
                if (mod_o !== m) begin
                    if (errs == 0) begin act1 = int'(mod_o); exp1 = int'(m); end
                    errs++;
                end
                @(negedge clk);
            end
        end
        chk(errs == 0, tag, act1, exp1);
    endtask

    task automatic send_bit(input bit b, input string tag);
        if (b) begin seg(1'b0, 1, tag); seg(1'b1, 1, tag); end
        else   begin seg(1'b1, 1, tag); seg(1'b0, 1, tag); end
    endtask

    task automatic run_frame(input int f, input int nb, input logic [7:0] b0,
                             input logic [7:0] b1, input logic [7:0] b2);
        string dt;
        @(negedge clk);
        dual_sc_i = f[2]; low_rate_i = f[1]; fast_i = f[0];
        fbytes[0] = b0; fbytes[1] = b1; fbytes[2] = b2; fbytes[3] = 8'h00;
        nb_cur = nb; idx = 0;
        chk(byte_ready_o == 1'b0, "R9 idle ready", int'(byte_ready_o), 0);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (dual_sc_i && fast_i) begin
            chk(illegal_o == 1'b1 && busy_o == 1'b0, "R8 flag", int'(illegal_o), 1);
            chk(mod_o == 1'b0 && byte_ready_o == 1'b0, "R8 quiet", int'(mod_o), 0);
            @(negedge clk);
            chk(illegal_o == 1'b0, "R8 one cycle", int'(illegal_o), 0);
            chk(idx == 0 && mod_o == 1'b0 && busy_o == 1'b0, "R8 nothing taken", idx, 0);
            return;
        end
        dt = dual_sc_i ? "R4/R10" : ((low_rate_i || fast_i) ? "R3" : "R2");
        seg(1'b0, 3, "R5");
        seg(1'b1, 3, "R5");
        send_bit(1'b1, "R5");
        for (int k = 0; k < nb; k++)
            for (int i = 0; i < 8; i++)
                send_bit(fbytes[k][i], dt);
        send_bit(1'b0, "R6");
        seg(1'b1, 3, "R6");
        seg(1'b0, 3, "R6");
        chk(done_o == 1'b1 && busy_o == 1'b0, "R6 done", int'(done_o), 1);
        chk(idx == nb, "R7 bytes consumed", idx, nb);
        chk(byte_ready_o == 1'b0, "R9 ready after frame", int'(byte_ready_o), 0);
        @(negedge clk);
        chk(done_o == 1'b0 && mod_o == 1'b0, "R6 done pulse width", int'(done_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk({mod_o, busy_o, byte_ready_o, done_o, illegal_o} == 5'b0, "R1 reset",
            int'({mod_o, busy_o, byte_ready_o, done_o, illegal_o}), 0);
        for (int f = 0; f < 8; f++)
            run_frame(f, 3, 8'(f * 59 + 23), 8'hA5, 8'(8'h5A ^ f));
        run_frame(0, 2, 8'h00, 8'hFF, 8'h00);
        run_frame(2, 1, 8'h80, 8'h00, 8'h00);
        run_frame(1, 2, 8'h01, 8'hFE, 8'h00);
        run_frame(4, 1, 8'hFF, 8'h00, 8'h00);
        run_frame(6, 2, 8'h00, 8'h81, 8'h00);
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 150000);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule